// File: doc/BRIEF.md
# Host-Visible UART Receive and Interrupt Identification Mimic

This block presents the receive side and the interrupt identification of a 16550-style UART to a host, while a local microprocessor stands in for the serial line. The local processor pushes bytes into a receive FIFO. It also raises line error flags (parity, framing, break), signals that the transmit holding register has been drained, and reports modem line levels. The host reads the receive buffer, the line status, the modem status and the interrupt identification byte. It writes a FIFO control byte and the transmit holding register.

A prioritising state machine picks which interrupt source the identification byte reports. Its state register holds the current source. It has the states `SRC_NONE`, `SRC_LINE`, `SRC_RXDATA`, `SRC_TIMEOUT`, `SRC_THRE` and `SRC_MODEM`. On every clock the machine moves from whatever state it is in to the highest-priority pending source, or to `SRC_NONE` when nothing is pending. The transitions are therefore "line error arrives", "data reaches trigger", "idle timeout fires", "transmitter drained", "modem line changed" and "all cleared". The identification byte and the interrupt output are decoded from that registered state.

A write-only modification byte from the local processor decides what happens to a push into a full FIFO. The push is either dropped or it replaces the newest stored byte.

Top module: `uart_rx_mimic`

## Requirements
- R1: After reset the host reads identification 0x01, line status 0x60 and modem status 0x00, and the host interrupt output is low.
- R2: Host reads at offset 0 return pushed bytes in push order and pop one entry. Line status bit 0 is 1 exactly while the FIFO holds data.
- R3: The modification byte is write-only and only its bit 1 (overwrite enable) has an effect. It is 0 after reset.
- R4: With overwrite disabled, a push into a full FIFO (with no host pop in the same cycle) is discarded, the FIFO contents are unchanged, and line status bit 1 (overrun) is set.
- R5: With overwrite enabled, such a push replaces the most recently stored byte and also sets line status bit 1.
- R6: The identification byte is {fifo_on, fifo_on, 0, 0, id[2:0], no_irq}. FIFO mode is bit 0 of the host byte written at offset 2. With no source pending, the low nibble is 0001. The byte reflects pending flags one clock after they change.
- R7: A line error (line status bits 4:1: break, framing, parity, overrun) gives id 011. A host line status read at offset 5 clears those bits and the interrupt.
- R8: Id 010 is reported while FIFO occupancy is at least the trigger level, and stops when occupancy falls below it. Host offset 2 bits 7:6 select trigger levels 1, 4, 8 and 14 (values 0..3). With FIFO mode off the level is 1.
- R9: In FIFO mode, id 110 is reported once the FIFO has held data for IDLE_LIMIT consecutive clocks without a push or a pop. A host pop clears it.
- R10: A transmitter-drained pulse from the processor gives id 001 and sets line status bits 6:5. An identification read that reports 001 clears it. A host write at offset 0 clears it and clears line status bits 6:5.
- R11: A change on any modem line gives id 000. The modem status reads {lines[3:0], changed[3:0]}, and the host read at offset 6 clears the changed bits.
- R12: Priority, from highest to lowest: line error, then received data, then timeout, then transmitter drained, then modem change.
- R13: A push and a host pop in the same cycle on a full FIFO both take effect, with no overrun and no loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mpu_cfg_wr | input | 1 | Processor write strobe for the modification byte |
| mpu_cfg_data | input | 8 | Modification byte (bit 1 = overwrite on overrun) |
| mpu_push | input | 1 | Processor push strobe into the receive FIFO |
| mpu_data | input | 8 | Byte to push |
| mpu_err_set | input | 3 | Set line errors {break, framing, parity} |
| mpu_tx_done | input | 1 | Transmit holding register drained pulse |
| mpu_modem_wr | input | 1 | Modem line update strobe |
| mpu_modem_lines | input | 4 | Modem line levels |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 3 | Host register offset |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (combinational for the current offset) |
| host_irq | output | 1 | High while any source is reported |

## Verification
Two functions can fall in the same cycle: the processor pushing into a full FIFO, and the host popping it. The bench fills the FIFO and then drives both strobes in one clock. It then judges the result from the line status, which must show data but no overrun. It also reads the FIFO back completely, and the new byte must appear after the fifteen older ones. A second case puts several interrupt sources pending at once and checks that they are reported strictly in priority order as each one is cleared through its own host action.

// File: rtl/uart_mimic_pkg.sv
package uart_mimic_pkg;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_LINE,
        SRC_RXDATA,
        SRC_TIMEOUT,
        SRC_THRE,
        SRC_MODEM
    } irq_src_e;

    localparam logic [2:0] OFS_DATA  = 3'd0;
    localparam logic [2:0] OFS_IDENT = 3'd2;
    localparam logic [2:0] OFS_LSTAT = 3'd5;
    localparam logic [2:0] OFS_MSTAT = 3'd6;

endpackage

// File: rtl/rx_fifo.sv
module rx_fifo #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      push,
    input  logic                      pop,
    input  logic                      overwrite_en,
    input  logic [DATA_W-1:0]         wdata,
    output logic [DATA_W-1:0]         head,
    output logic [$clog2(DEPTH):0]    count,
    output logic                      overrun_evt
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic              full, pop_ok, push_take, overwrite;

    assign full        = (count == CW'(DEPTH));
    assign pop_ok      = pop && (count != '0);
    assign push_take   = push && (!full || pop_ok);
    assign overwrite   = push && full && !pop_ok && overwrite_en;
    assign overrun_evt = push && full && !pop_ok;
    assign head        = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_take) begin
            mem[wr_ptr] <= wdata;
        end else if (overwrite) begin
            mem[wr_ptr - AW'(1)] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_take) wr_ptr <= wr_ptr + AW'(1);
            if (pop_ok)    rd_ptr <= rd_ptr + AW'(1);
            unique case ({push_take, pop_ok})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    p_drop_keeps_state_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !overwrite_en) |=> ($stable(count) && $stable(wr_ptr)));

    p_overwrite_stays_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && overwrite_en) |=> (count == CW'(DEPTH)));

    p_same_cycle_no_loss_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && full) |=> (count == CW'(DEPTH)));
endmodule

// File: rtl/rx_timeout.sv
module rx_timeout #(
    parameter int IDLE_LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic has_data,
    input  logic push,
    input  logic pop,
    output logic to_flag
);
    localparam int CNTW = $clog2(IDLE_LIMIT + 1);

    logic [CNTW-1:0] idle_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_cnt <= '0;
            to_flag  <= 1'b0;
        end else if (!enable || !has_data || pop) begin
            idle_cnt <= '0;
            to_flag  <= 1'b0;
        end else if (push) begin
            idle_cnt <= '0;
        end else if (!to_flag) begin
            if (idle_cnt == CNTW'(IDLE_LIMIT - 1)) begin
                to_flag <= 1'b1;
            end else begin
                idle_cnt <= idle_cnt + CNTW'(1);
            end
        end
    end

    p_to_needs_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        to_flag |-> has_data);

    p_pop_clears_to_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> !to_flag);
endmodule

// File: rtl/iir_arbiter.sv
module iir_arbiter
    import uart_mimic_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     fifo_on,
    input  logic     line_pend,
    input  logic     rxd_pend,
    input  logic     to_pend,
    input  logic     thre_pend,
    input  logic     msr_pend,
    output irq_src_e cur_src,
    output logic [7:0] ident
);
    irq_src_e   next_src;
    logic [2:0] id_code;

    always_comb begin
        if (line_pend)      next_src = SRC_LINE;
        else if (rxd_pend)  next_src = SRC_RXDATA;
        else if (to_pend)   next_src = SRC_TIMEOUT;
        else if (thre_pend) next_src = SRC_THRE;
        else if (msr_pend)  next_src = SRC_MODEM;
        else                next_src = SRC_NONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_src <= SRC_NONE;
        else        cur_src <= next_src;
    end

    always_comb begin
        unique case (cur_src)
            SRC_LINE:    id_code = 3'b011;
            SRC_RXDATA:  id_code = 3'b010;
            SRC_TIMEOUT: id_code = 3'b110;
            SRC_THRE:    id_code = 3'b001;
            SRC_MODEM:   id_code = 3'b000;
            default:     id_code = 3'b000;
        endcase
        ident = {fifo_on, fifo_on, 2'b00, id_code, cur_src == SRC_NONE};
    end

    p_line_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        line_pend |=> (cur_src == SRC_LINE));

    p_modem_last_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_pend && !line_pend && !rxd_pend && !to_pend && !thre_pend)
            |=> (cur_src == SRC_MODEM));

    p_quiet_means_none_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_pend || rxd_pend || to_pend || thre_pend || msr_pend)
            |=> (cur_src == SRC_NONE));
endmodule

// File: rtl/uart_rx_mimic.sv
module uart_rx_mimic
    import uart_mimic_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int IDLE_LIMIT = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mpu_cfg_wr,
    input  logic [7:0] mpu_cfg_data,
    input  logic       mpu_push,
    input  logic [7:0] mpu_data,
    input  logic [2:0] mpu_err_set,
    input  logic       mpu_tx_done,
    input  logic       mpu_modem_wr,
    input  logic [3:0] mpu_modem_lines,
    input  logic       host_rd,
    input  logic       host_wr,
    input  logic [2:0] host_addr,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    output logic       host_irq
);
    localparam int CW = $clog2(DEPTH) + 1;

    logic          ovw_en, fifo_on, thr_empty, thre_pend;
    logic [1:0]    trig_sel;
    logic [3:0]    err_bits;   // {break, framing, parity, overrun}
    logic [3:0]    lines, deltas;
    logic [CW-1:0] count, trig_level;
    logic [7:0]    head, ident, lstat, mstat;
    logic          pop, overrun_evt, to_flag;
    logic          rd_lstat, rd_mstat, rd_ident, wr_thr, wr_fcr;
    irq_src_e      cur_src;

    assign pop      = host_rd && (host_addr == OFS_DATA) && (count != '0);
    assign rd_lstat = host_rd && (host_addr == OFS_LSTAT);
    assign rd_mstat = host_rd && (host_addr == OFS_MSTAT);
    assign rd_ident = host_rd && (host_addr == OFS_IDENT);
    assign wr_thr   = host_wr && (host_addr == OFS_DATA);
    assign wr_fcr   = host_wr && (host_addr == OFS_IDENT);

    always_comb begin
        if (!fifo_on) trig_level = CW'(1);
        else begin
            unique case (trig_sel)
                2'd0: trig_level = CW'(1);
                2'd1: trig_level = CW'(DEPTH / 4);
                2'd2: trig_level = CW'(DEPTH / 2);
                2'd3: trig_level = CW'(DEPTH - 2);
                default: trig_level = CW'(1);
            endcase
        end
    end

    rx_fifo #(.DEPTH(DEPTH), .DATA_W(8)) i_fifo (
        .clk(clk), .rst_n(rst_n), .push(mpu_push), .pop(pop),
        .overwrite_en(ovw_en), .wdata(mpu_data), .head(head),
        .count(count), .overrun_evt(overrun_evt)
    );

    rx_timeout #(.IDLE_LIMIT(IDLE_LIMIT)) i_timeout (
        .clk(clk), .rst_n(rst_n), .enable(fifo_on), .has_data(count != '0),
        .push(mpu_push), .pop(pop), .to_flag(to_flag)
    );

    iir_arbiter i_arb (
        .clk(clk), .rst_n(rst_n), .fifo_on(fifo_on),
        .line_pend(|err_bits), .rxd_pend(count >= trig_level),
        .to_pend(to_flag), .thre_pend(thre_pend), .msr_pend(|deltas),
        .cur_src(cur_src), .ident(ident)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovw_en    <= 1'b0;
            fifo_on   <= 1'b0;
            trig_sel  <= 2'd0;
            thr_empty <= 1'b1;
            thre_pend <= 1'b0;
            err_bits  <= '0;
            lines     <= '0;
            deltas    <= '0;
        end else begin
            if (mpu_cfg_wr) ovw_en <= mpu_cfg_data[1];
            if (wr_fcr) begin
                fifo_on  <= host_wdata[0];
                trig_sel <= host_wdata[7:6];
            end
            if (mpu_tx_done) begin
                thr_empty <= 1'b1;
                thre_pend <= 1'b1;
            end else if (wr_thr) begin
                thr_empty <= 1'b0;
                thre_pend <= 1'b0;
            end else if (rd_ident && cur_src == SRC_THRE) begin
                thre_pend <= 1'b0;
            end
            err_bits <= (rd_lstat ? 4'b0000 : err_bits) | {mpu_err_set, overrun_evt};
            if (mpu_modem_wr) lines <= mpu_modem_lines;
            deltas <= (rd_mstat ? 4'b0000 : deltas)
                    | (mpu_modem_wr ? (mpu_modem_lines ^ lines) : 4'b0000);
        end
    end

    assign lstat = {|err_bits, thr_empty, thr_empty, err_bits, count != '0};
    assign mstat = {lines, deltas};

    always_comb begin
        unique case (host_addr)
            OFS_DATA:  host_rdata = (count != '0) ? head : 8'h00;
            OFS_IDENT: host_rdata = ident;
            OFS_LSTAT: host_rdata = lstat;
            OFS_MSTAT: host_rdata = mstat;
            default:   host_rdata = 8'h00;
        endcase
    end

    assign host_irq = (cur_src != SRC_NONE);

    p_lsr_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lstat && mpu_err_set == 3'b000 && !overrun_evt) |=> (err_bits == 4'b0000));

    p_thr_write_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_thr && !mpu_tx_done) |=> (!thre_pend && !thr_empty));

    p_msr_read_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_mstat && !mpu_modem_wr) |=> (deltas == 4'b0000));

    p_overrun_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_evt |=> err_bits[0]);
endmodule

// File: tb/test_uart_rx_mimic.sv
module test_uart_rx_mimic;
    localparam int TO = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mpu_cfg_wr = 1'b0, mpu_push = 1'b0, mpu_tx_done = 1'b0, mpu_modem_wr = 1'b0;
    logic [7:0] mpu_cfg_data = '0, mpu_data = '0;
    logic [2:0] mpu_err_set = '0;
    logic [3:0] mpu_modem_lines = '0;
    logic       host_rd = 1'b0, host_wr = 1'b0;
    logic [2:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       host_irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    uart_rx_mimic #(.DEPTH(16), .IDLE_LIMIT(TO)) i_uart_rx_mimic (
        .clk(clk), .rst_n(rst_n),
        .mpu_cfg_wr(mpu_cfg_wr), .mpu_cfg_data(mpu_cfg_data),
        .mpu_push(mpu_push), .mpu_data(mpu_data), .mpu_err_set(mpu_err_set),
        .mpu_tx_done(mpu_tx_done), .mpu_modem_wr(mpu_modem_wr),
        .mpu_modem_lines(mpu_modem_lines),
        .host_rd(host_rd), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_irq(host_irq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic push(input logic [7:0] d);
        mpu_push = 1'b1; mpu_data = d;
        tick();
        mpu_push = 1'b0;
    endtask

    task automatic hread(input logic [2:0] a, output logic [7:0] d);
        host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        tick();
        host_rd = 1'b0;
    endtask

    task automatic iir(output logic [7:0] d);
        tick();
        hread(3'd2, d);
    endtask

    task automatic hwrite(input logic [2:0] a, input logic [7:0] d);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        tick();
        host_wr = 1'b0;
    endtask

    task automatic cfg(input logic [7:0] d);
        mpu_cfg_data = d; mpu_cfg_wr = 1'b1;
        tick();
        mpu_cfg_wr = 1'b0;
    endtask

    task automatic push_pop(input logic [7:0] d, output logic [7:0] q);
        mpu_push = 1'b1; mpu_data = d;
        host_addr = 3'd0; host_rd = 1'b1;
        #1 q = host_rdata;
        tick();
        mpu_push = 1'b0; host_rd = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        int trig;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 irq", {7'b0, host_irq}, 8'h00);
        iir(d);           check("R1 ident", d, 8'h01);
        hread(3'd5, d);   check("R1 lstat", d, 8'h60);
        hread(3'd6, d);   check("R1 mstat", d, 8'h00);

        // R8 / R2 sweep over trigger levels
        for (int sel = 0; sel < 4; sel++) begin
            trig = (sel == 0) ? 1 : (sel == 1) ? 4 : (sel == 2) ? 8 : 14;
            hwrite(3'd2, 8'((sel << 6) | 1));
            for (int n = 1; n <= 16; n++) begin
                push(8'(sel * 16 + n));
                iir(d); check("R8 fill", d, (n >= trig) ? 8'hC4 : 8'hC1);
            end
            for (int k = 1; k <= 16; k++) begin
                hread(3'd0, d); check("R2 order", d, 8'(sel * 16 + k));
                iir(d); check("R8 drain", d, ((16 - k) >= trig) ? 8'hC4 : 8'hC1);
            end
            hread(3'd5, d); check("R2 empty lstat", d, 8'h60);
        end

        // R3 / R4 overrun with overwrite off (reserved bits set, bit 1 clear)
        cfg(8'hFD);
        for (int i = 0; i < 16; i++) push(8'(8'hA0 + i));
        push(8'h55);
        iir(d);           check("R4 ident line", d, 8'hC6);
        hread(3'd5, d);   check("R4 lstat overrun", d, 8'hE3);
        hread(3'd5, d);   check("R7 lstat cleared", d, 8'h61);
        iir(d);           check("R7 ident after clear", d, 8'hC4);
        for (int i = 0; i < 16; i++) begin
            hread(3'd0, d); check("R3 R4 dropped push", d, 8'(8'hA0 + i));
        end

        // R5 overwrite on
        cfg(8'h02);
        for (int i = 0; i < 16; i++) push(8'(8'hB0 + i));
        push(8'h77);
        hread(3'd5, d);   check("R5 lstat overrun", d, 8'hE3);
        for (int i = 0; i < 15; i++) begin
            hread(3'd0, d); check("R5 older bytes", d, 8'(8'hB0 + i));
        end
        hread(3'd0, d);   check("R5 newest replaced", d, 8'h77);

        // R13 push and pop in the same cycle on a full FIFO
        for (int i = 0; i < 16; i++) push(8'(8'hC0 + i));
        push_pop(8'h99, d); check("R13 popped head", d, 8'hC0);
        hread(3'd5, d);   check("R13 no overrun", d, 8'h61);
        for (int i = 1; i < 16; i++) begin
            hread(3'd0, d); check("R13 order", d, 8'(8'hC0 + i));
        end
        hread(3'd0, d);   check("R13 new byte kept", d, 8'h99);

        // R9 timeout, trigger level 4
        hwrite(3'd2, 8'h41);
        push(8'h3C);
        repeat (TO - 1) tick();
        iir(d);           check("R9 not yet", d, 8'hC1);
        iir(d);           check("R9 timeout", d, 8'hCC);
        hread(3'd0, d);   check("R9 data", d, 8'h3C);
        iir(d);           check("R9 cleared by pop", d, 8'hC1);

        // R6 FIFO mode off: no timeout, trigger 1, top bits clear
        hwrite(3'd2, 8'h00);
        push(8'h5A);
        repeat (TO + 10) tick();
        iir(d);           check("R6 non-fifo ident", d, 8'h04);
        hread(3'd0, d);   check("R6 non-fifo data", d, 8'h5A);
        iir(d);           check("R6 non-fifo idle", d, 8'h01);
        hwrite(3'd2, 8'h01);

        // R10 transmitter drained
        mpu_tx_done = 1'b1; tick(); mpu_tx_done = 1'b0;
        iir(d);           check("R10 ident", d, 8'hC2);
        iir(d);           check("R10 cleared by ident read", d, 8'hC1);
        mpu_tx_done = 1'b1; tick(); mpu_tx_done = 1'b0;
        hwrite(3'd0, 8'hAA);
        iir(d);           check("R10 cleared by thr write", d, 8'hC1);
        hread(3'd5, d);   check("R10 lstat thr busy", d, 8'h00);
        mpu_tx_done = 1'b1; tick(); mpu_tx_done = 1'b0;
        hread(3'd5, d);   check("R10 lstat thr empty", d, 8'h60);
        iir(d);           check("R10 ident again", d, 8'hC2);

        // R11 modem change
        mpu_modem_lines = 4'b0001; mpu_modem_wr = 1'b1; tick(); mpu_modem_wr = 1'b0;
        iir(d);           check("R11 ident", d, 8'hC0);
        hread(3'd6, d);   check("R11 mstat", d, 8'h11);
        iir(d);           check("R11 cleared", d, 8'hC1);
        hread(3'd6, d);   check("R11 mstat after read", d, 8'h10);

        // R12 priority with all sources pending
        mpu_modem_lines = 4'b0011; mpu_modem_wr = 1'b1; tick(); mpu_modem_wr = 1'b0;
        mpu_tx_done = 1'b1; tick(); mpu_tx_done = 1'b0;
        push(8'h42);
        mpu_err_set = 3'b001; tick(); mpu_err_set = 3'b000;
        iir(d);           check("R12 line first", d, 8'hC6);
        hread(3'd5, d);   check("R12 lstat parity", d, 8'hE5);
        iir(d);           check("R12 data second", d, 8'hC4);
        hread(3'd0, d);   check("R12 data byte", d, 8'h42);
        iir(d);           check("R12 thre third", d, 8'hC2);
        iir(d);           check("R12 modem last", d, 8'hC0);
        hread(3'd6, d);   check("R12 mstat", d, 8'h32);
        iir(d);           check("R12 all clear", d, 8'hC1);
        check("R12 irq low", {7'b0, host_irq}, 8'h00);

        finish_run();
    end
endmodule